// File: doc/BRIEF.md
# Fan Tachometer Speed Meter

This block turns the open-collector speed signal of a cooling fan into a revolutions-per-minute figure. The raw signal is brought into the reference clock domain through a two-stage synchroniser. A debouncer then accepts a level change only after a fixed quiet window has run out since the previous accepted change. Rising edges that pass the debouncer bound the measurement windows. The block counts reference clocks across a fixed number of full signal cycles, then hands that count to a bit-serial restoring divider. The divider returns the speed directly, so the ratio is taken in one step and no separate frequency value is formed.

The scale constant is the number of cycles per window, times the reference rate, times sixty, divided by the pulses the fan makes per revolution. It counts pulses, not level changes. With the default parameters (16 cycles, 187.5 MHz, 2 pulses per revolution) the constant is 9e10. A fan that stops, or never starts, produces no edges. After a fixed idle limit the block reports zero and begins a fresh window. A register interface can read the speed at any time. A one-cycle strobe marks each new value.

Top module: `tach_rpm_meter`

## Requirements
- R1: The tach input passes through two synchroniser flops. A change driven just after an edge is accepted on the third rising clock edge that follows.
- R2: Once a level change has been accepted, any further change of the synchronised input within the next DEAD_CLKS clocks is ignored. A pulse that begins and ends inside that window changes nothing.
- R3: A window starts at an accepted rising edge and closes at the CYCLES-th accepted rising edge after it. The closing edge also opens the next window, so back-to-back results each cover a full window.
- R4: The reported speed is floor(S / N). N is the number of reference clocks between the opening and closing edges. S = CYCLES × REF_HZ × 60 / PULSES_PER_REV, with each pulse being one full high-low cycle of the tach signal.
- R5: If no rising edge is accepted for 2^IDLE_LOG2 clocks, the block reports 0. It then discards the partial window, so the next rising edge opens a new one.
- R6: The divider captures its operands on the cycle after a window closes. It writes its result W clock edges later, where W = ceil(log2(S+1)). The strobe is therefore seen W+4 edges after the closing rising edge is driven.
- R7: rpm_o changes only in a cycle in which rpm_valid_o is high. rpm_valid_o is high for one cycle per result.
- R8: During reset, rpm_o is 0 and rpm_valid_o and busy_o are low.
- R9: busy_o is high for exactly W cycles before each strobe, while the divider iterates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tach_i | input | 1 | Raw fan tachometer signal, asynchronous |
| rpm_o | output | RPM_W | Last computed speed in revolutions per minute |
| rpm_valid_o | output | 1 | One-cycle strobe marking a new rpm_o value |
| busy_o | output | 1 | High while the divider is iterating |

## Verification
The bench notes the cycle in which it drives the opening rising edge of a window. The closing edge falls CYCLES periods later, and the strobe must appear exactly W+4 cycles after that edge. During those W cycles busy must be high throughout. A zero result is due 2^IDLE_LOG2 + W + 1 edges after the last accepted rise, so the bench stalls the input and waits a bounded number of cycles for it. Before each speed test the bench lets a zero result clear any partial window. Each expected value is then tied to a window whose edges the bench placed itself. All outputs are sampled on the falling clock edge, half a cycle after the register that drives them has settled.

// File: rtl/tach_pkg.sv
package tach_pkg;

  // Numerator of the speed ratio: window cycles * reference rate * 60 / pulses per revolution.
  function automatic longint unsigned rpm_scale(input int unsigned cycles,
                                                input int unsigned ref_hz,
                                                input int unsigned ppr);
    longint unsigned prod;
    prod = longint'(cycles) * longint'(ref_hz) * 64'd60;
    return prod / longint'(ppr);
  endfunction

  // One restoring step: does the shifted partial remainder cover the divisor?
  function automatic logic step_fits(input logic [63:0] trial, input logic [63:0] den);
    return trial >= den;
  endfunction

endpackage

// File: rtl/tach_edge_filter.sv
module tach_edge_filter #(
  parameter int DEAD_CLKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tach_i,
  output logic rise_o
);
  localparam int DW = $clog2(DEAD_CLKS + 1);

  logic [1:0]    sync_q;
  logic          deb_q;
  logic [DW-1:0] dead_q;
  logic          sync_lvl;
  logic          take;

  assign sync_lvl = sync_q[1];

  // Accept a level change only once the quiet window has expired.
  always_comb take = (sync_lvl != deb_q) && (dead_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q <= '0;
      deb_q  <= 1'b0;
      dead_q <= '0;
    end else begin
      sync_q <= {sync_q[0], tach_i};
      if (take) begin
        deb_q  <= sync_lvl;
        dead_q <= DW'(DEAD_CLKS);
      end else if (dead_q != '0) begin
        dead_q <= dead_q - 1'b1;
      end
    end
  end

  assign rise_o = take & sync_lvl;

  // R2: while the quiet window runs, the filtered level cannot move
  a_r2_dead_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_q != '0) |=> $stable(deb_q));

  // R1: a filtered rise reflects the raw input three edges earlier
  a_r1_sync_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deb_q) |-> $past(tach_i, 3));

endmodule

// File: rtl/tach_period.sv
module tach_period #(
  parameter int CYCLES     = 16,
  parameter int CNT_W      = 32,
  parameter int IDLE_LOG2  = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             req_o,
  output logic [CNT_W-1:0] span_o
);
  localparam int EW = $clog2(CYCLES + 1);

  logic                 armed_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [EW-1:0]        edges_q;
  logic [IDLE_LOG2-1:0] idle_q;
  logic                 req_q;
  logic [CNT_W-1:0]     span_q;
  logic                 stall;
  logic                 closing;

  assign stall   = &idle_q;
  assign closing = armed_q && rise_i && (edges_q == EW'(CYCLES - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      edges_q <= '0;
      idle_q  <= '0;
      req_q   <= 1'b0;
      span_q  <= '0;
    end else begin
      req_q  <= 1'b0;
      idle_q <= (rise_i || stall) ? '0 : idle_q + 1'b1;
      if (rise_i) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
          edges_q <= '0;
        end else if (closing) begin
          req_q   <= 1'b1;
          span_q  <= cnt_q + 1'b1;
          cnt_q   <= '0;
          edges_q <= '0;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          edges_q <= edges_q + 1'b1;
        end
      end else if (stall) begin
        armed_q <= 1'b0;
        req_q   <= 1'b1;
        span_q  <= '0;
      end else if (armed_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign span_o = span_q;

  // R5: a zero-span request only follows a stall, which leaves the window disarmed
  a_r5_stall_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && span_q == '0) |-> !armed_q);

  // R3: a closed window always spans at least one clock per cycle
  a_r3_span_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && span_q != '0) |-> (span_q >= CNT_W'(CYCLES)));

endmodule

// File: rtl/tach_serdiv.sv
module tach_serdiv #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 32,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic [OUT_W-1:0] quo_o,
  output logic             valid_o
);
  localparam int IW = $clog2(NUM_W + 1);

  logic             busy_q;
  logic [NUM_W-1:0] dvd_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [IW-1:0]    step_q;
  logic [OUT_W-1:0] out_q;
  logic             valid_q;

  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;
  logic [DEN_W-1:0] rem_nx;
  logic [NUM_W-1:0] quo_nx;
  logic             last_step;

  always_comb begin
    trial     = {rem_q, dvd_q[NUM_W-1]};
    fits      = tach_pkg::step_fits(64'(trial), 64'(den_q));
    diff      = trial - {1'b0, den_q};
    rem_nx    = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    quo_nx    = {quo_q[NUM_W-2:0], fits};
    last_step = (step_q == IW'(NUM_W - 1));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      dvd_q   <= '0;
      den_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      step_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          // operands are captured here; the ports are not read again
          busy_q <= 1'b1;
          dvd_q  <= num_i;
          den_q  <= den_i;
          rem_q  <= '0;
          quo_q  <= '0;
          step_q <= '0;
        end
      end else begin
        rem_q  <= rem_nx;
        quo_q  <= quo_nx;
        dvd_q  <= dvd_q << 1;
        step_q <= step_q + 1'b1;
        if (last_step) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
          out_q   <= (den_q == '0) ? '0 : OUT_W'(quo_nx);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign quo_o   = out_q;
  assign valid_o = valid_q;

  // R7: the result holds between strobes
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(out_q));

  // R7: one strobe cycle per result
  a_r7_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R9: every strobe is preceded by a busy cycle
  a_r9_busy_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(busy_q));

  // R6: the partial remainder stays below the captured divisor
  a_r6_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ((den_q == '0) || (rem_q < den_q)));

endmodule

// File: rtl/tach_rpm_meter.sv
module tach_rpm_meter #(
  parameter int unsigned REF_HZ         = 187_500_000,
  parameter int          CYCLES         = 16,
  parameter int unsigned PULSES_PER_REV = 2,
  parameter int          DEAD_CLKS      = 1000,
  parameter int          IDLE_LOG2      = 28,
  parameter int          CNT_W          = 32,
  parameter int          RPM_W          = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tach_i,
  output logic [RPM_W-1:0] rpm_o,
  output logic             rpm_valid_o,
  output logic             busy_o
);
  localparam longint unsigned SCALE =
    tach_pkg::rpm_scale(CYCLES, REF_HZ, PULSES_PER_REV);
  localparam int NUM_W = $clog2(SCALE + 1);

  logic             rise;
  logic             req;
  logic [CNT_W-1:0] span;

  tach_edge_filter #(.DEAD_CLKS(DEAD_CLKS)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  tach_period #(.CYCLES(CYCLES), .CNT_W(CNT_W), .IDLE_LOG2(IDLE_LOG2)) u_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .req_o  (req),
    .span_o (span)
  );

  tach_serdiv #(.NUM_W(NUM_W), .DEN_W(CNT_W), .OUT_W(RPM_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req),
    .num_i   (NUM_W'(SCALE)),
    .den_i   (span),
    .busy_o  (busy_o),
    .quo_o   (rpm_o),
    .valid_o (rpm_valid_o)
  );

endmodule

// File: tb/tach_rpm_meter_test.sv
module tach_rpm_meter_test;
  localparam int unsigned T_REF  = 1000;
  localparam int          T_CYC  = 4;
  localparam int unsigned T_PPR  = 2;
  localparam int          T_DEAD = 8;
  localparam int          T_IDLE = 12;

  function automatic longint unsigned scale_of();
    return (longint'(T_CYC) * 60 * longint'(T_REF)) / longint'(T_PPR);
  endfunction
  function automatic longint unsigned speed_of(input longint unsigned period);
    return scale_of() / (longint'(T_CYC) * period);
  endfunction
  localparam int DW = $clog2(120001); // width of the scale for these parameters

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tach = 1'b0;
  logic [31:0] rpm;
  logic        rpm_valid;
  logic        busy;

  always #4 clk = ~clk;

  tach_rpm_meter #(
    .REF_HZ(T_REF), .CYCLES(T_CYC), .PULSES_PER_REV(T_PPR),
    .DEAD_CLKS(T_DEAD), .IDLE_LOG2(T_IDLE), .CNT_W(32), .RPM_W(32)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .tach_i(tach),
    .rpm_o(rpm), .rpm_valid_o(rpm_valid), .busy_o(busy)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  longint      cyc   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // falling-edge monitor: captures up to two strobes after being armed
  int          cap_n = 2;
  longint      cap_c [2];
  longint      cap_v [2];
  int          cap_b [2];
  int          bcount = 0;
  int          hold_bad = 0;
  logic [31:0] prev_rpm = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) bcount++;
      if (!rpm_valid && rpm != prev_rpm) hold_bad++;
      if (rpm_valid) begin
        if (cap_n < 2) begin
          cap_c[cap_n] = cyc;
          cap_v[cap_n] = longint'(rpm);
          cap_b[cap_n] = bcount;
          cap_n++;
        end
        bcount = 0;
      end
      prev_rpm = rpm;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_caps(input int want, input int limit);
    for (int i = 0; i < limit && cap_n < want; i++) @(negedge clk);
  endtask

  // R5: stall the input and expect a zero result from the idle limit
  task automatic stall_zero();
    @(negedge clk);
    tach = 1'b0;
    cap_n = 0;
    wait_caps(1, (1 << T_IDLE) + DW + 200);
    chk(cap_n >= 1 && cap_v[0] == 0, "R5 idle result", cap_n >= 1 ? cap_v[0] : -1, 0);
    cap_n = 2;
  endtask

  // drive periods of high h1 / low h2; optional short pulses inside the quiet window
  task automatic wave(input int h1, input int h2, input int periods, input bit glitch,
                      output longint start);
    @(negedge clk);
    start = cyc;
    for (int p = 0; p <= periods; p++) begin
      tach = 1'b1;
      if (glitch) begin
        repeat (2) @(negedge clk);
        tach = 1'b0;
        repeat (2) @(negedge clk);
        tach = 1'b1;
        repeat (h1 - 4) @(negedge clk);
      end else begin
        repeat (h1) @(negedge clk);
      end
      tach = 1'b0;
      if (glitch) begin
        repeat (2) @(negedge clk);
        tach = 1'b1;
        repeat (2) @(negedge clk);
        tach = 1'b0;
        repeat (h2 - 4) @(negedge clk);
      end else begin
        repeat (h2) @(negedge clk);
      end
    end
  endtask

  task automatic speed_test(input int h1, input int h2, input bit glitch, input string tag);
    longint st;
    stall_zero();
    cap_n = 0;
    wave(h1, h2, T_CYC, glitch, st);
    wait_caps(1, 200);
    chk(cap_n >= 1 && cap_v[0] == longint'(speed_of(h1 + h2)), tag,
        cap_n >= 1 ? cap_v[0] : -1, longint'(speed_of(h1 + h2)));
    cap_n = 2;
  endtask

  initial begin
    longint st;
    int     h1;
    int     h2;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(rpm == 0, "R8 rpm in reset", longint'(rpm), 0);
    chk(!rpm_valid, "R8 strobe in reset", longint'(rpm_valid), 0);
    chk(!busy, "R8 busy in reset", longint'(busy), 0);
    rst_n = 1'b1;

    // directed: shortest legal half period, two back-to-back windows (R1, R3, R4, R6, R9)
    stall_zero();
    cap_n = 0;
    wave(9, 9, 2 * T_CYC, 1'b0, st);
    wait_caps(2, 300);
    chk(cap_n == 2 && cap_v[0] == longint'(speed_of(18)), "R4 speed min period",
        cap_v[0], longint'(speed_of(18)));
    chk(cap_c[0] == st + T_CYC * 18 + DW + 4, "R1 R6 strobe latency",
        cap_c[0], st + T_CYC * 18 + DW + 4);
    chk(cap_b[0] == DW, "R9 busy cycles", cap_b[0], DW);
    chk(cap_n == 2 && cap_v[1] == longint'(speed_of(18)), "R3 next window",
        cap_v[1], longint'(speed_of(18)));
    chk(cap_c[1] - cap_c[0] == T_CYC * 18, "R3 window spacing",
        cap_c[1] - cap_c[0], T_CYC * 18);
    cap_n = 2;

    // random periods, including uneven duty (R4)
    for (int k = 0; k < 8; k++) begin
      h1 = T_DEAD + 1 + int'($urandom_range(50));
      h2 = T_DEAD + 1 + int'($urandom_range(50));
      speed_test(h1, h2, 1'b0, "R4 random period");
    end

    // short pulses inside the quiet window are ignored (R2)
    speed_test(20, 25, 1'b1, "R2 debounce");
    // long period, small result (R4)
    speed_test(300, 300, 1'b0, "R4 long period");
    // after the long run, stalling still yields zero (R5)
    stall_zero();

    chk(hold_bad == 0, "R7 value held between strobes", hold_bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule